// File: doc/BRIEF.md
# IR Receiver Symbol Buffer and Interrupt Controller

This block sits between an infrared pulse-capture engine and the processor. It holds the control word the capture engine runs with, buffers the captured symbols in a first-in first-out store, and turns three kinds of receive events into one interrupt line. Software reaches it through a simple 32-bit register bus. Each access lasts one cycle and is marked by `bus_sel`, with `bus_wr` selecting write or read. Read data is combinational in the same cycle.

A small controller sets when the capture engine may deliver data. It has three states. **OFF** is the reset state, and the engine is disabled in it. **IDLE** means the engine is enabled but not yet started. **RUN** means symbols and timeouts are accepted. The transitions are: *arm* (OFF to IDLE, on a write of 1 to bit 0 of the enable register); *go* (IDLE to RUN, on any write to the start register); *disarm* (IDLE or RUN to OFF, on a write of 0 to bit 0 of the enable register). A start write in OFF is ignored. Disarm takes priority over all other transitions.

Software reads the symbol count, then reads the data register once per symbol. Each data read removes the oldest symbol. Status shows each event twice: once as a raw latch and once gated by the mask.

Top module: `ir_rx_regs`

## Requirements
- R1: After reset, the controller is in OFF (`cap_enable`=0, `cap_run`=0), the FIFO is empty, all status bits are 0, and `irq` is 0.
- R2: Symbols on `sym_valid` and pulses on `timeout_evt` are accepted only in RUN. OFF/IDLE/RUN follow the arm, go and disarm transitions, and a start write in OFF has no effect.
- R3: A read at 0x20 returns the number of stored symbols (0 to 64) in the low bits.
- R4: A read at 0x24 returns the oldest stored symbol and removes it, so symbols come out in arrival order.
- R5: A read at 0x24 with the FIFO empty returns 0 and leaves the count at 0.
- R6: Raw receive bit 24 of status (0x2C) is set whenever the stored count is at least the level in config bits [13:8] plus one. Writing its clear bit while the count is still at or above that threshold leaves it set.
- R7: A `timeout_evt` pulse in RUN sets raw bit 25 of status.
- R8: A symbol that arrives while 64 symbols are held is dropped and sets raw bit 26. The stored symbols are kept unchanged and can be drained in order.
- R9: Status bits [10:8] equal raw bits [26:24] gated by mask register (0x28) bits [2:0], where 1 blocks the event and 0 enables it. `irq` is the OR of bits [10:8].
- R10: In the clear register (0x30), writing 1 to bit 16, 17 or 18 clears the receive, timeout or overflow latch respectively. A 0 in any of those bits leaves that latch unchanged.
- R11: Config (0x04) and mask (0x28) read back what was written, and config drives `cap_config`. Bit 0 of 0x1C reflects `cap_busy`, and bit 0 of 0x00 reflects `cap_enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| sym_valid | input | 1 | Capture engine delivers a symbol |
| sym_data | input | 32 | Captured symbol |
| timeout_evt | input | 1 | Capture engine reports end-of-stream timeout |
| cap_busy | input | 1 | Capture engine busy indication |
| cap_enable | output | 1 | Engine enabled (IDLE or RUN) |
| cap_run | output | 1 | Engine started (RUN) |
| cap_config | output | 32 | Control word for the engine |
| irq | output | 1 | Combined interrupt |

## Verification
The bench checks several corner cases, and each one catches a specific fault:
- **Full FIFO.** Pushing into a full FIFO must drop the new symbol and keep the oldest one intact. A design that overwrote the head or advanced the write pointer would return the wrong first or last symbol.
- **Threshold edge.** The receive latch must stay clear at exactly the configured level and set one symbol later. An off-by-one compare would show up here.
- **Clear while above threshold.** Clearing the receive latch while the count is still above threshold must leave it set. A design where clear wins over a persisting condition would drop the bit.
- **Empty read.** Reading data from an empty FIFO must return 0 and keep the count at 0. A design that popped without gating would wrap the count.
- **Masking and gating.** Masking must hide only the gated copy and leave the raw bit visible. Symbols offered in OFF and IDLE must leave the count untouched.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
    localparam logic [7:0] A_ENABLE = 8'h00;
    localparam logic [7:0] A_CONFIG = 8'h04;
    localparam logic [7:0] A_BUSY   = 8'h1C;
    localparam logic [7:0] A_COUNT  = 8'h20;
    localparam logic [7:0] A_DATA   = 8'h24;
    localparam logic [7:0] A_MASK   = 8'h28;
    localparam logic [7:0] A_STATUS = 8'h2C;
    localparam logic [7:0] A_CLEAR  = 8'h30;
    localparam logic [7:0] A_START  = 8'h34;

    // Event index order inside every 3-bit event vector
    localparam int EV_RCV = 0;
    localparam int EV_TMO = 1;
    localparam int EV_OVF = 2;
    localparam int NUM_EV = 3;

    localparam int LVL_LSB = 8;
    localparam int LVL_W   = 6;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_RUN  = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/ir_rx_ctl.sv
module ir_rx_ctl
    import ir_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_bit,
    input  logic start_wr,
    output logic cap_enable,
    output logic cap_run
);
    ctl_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (en_wr && !en_bit) begin
            state_d = ST_OFF;                       // disarm
        end else begin
            unique case (state_q)
                ST_OFF:  if (en_wr && en_bit) state_d = ST_IDLE;   // arm
                ST_IDLE: if (start_wr)        state_d = ST_RUN;    // go
                ST_RUN:  state_d = ST_RUN;
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        cap_enable = 1'b0;
        cap_run    = 1'b0;
        unique case (state_q)
            ST_OFF:  ;
            ST_IDLE: cap_enable = 1'b1;
            ST_RUN:  begin cap_enable = 1'b1; cap_run = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/ir_sym_fifo.sv
module ir_sym_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          drop
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          full, do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign drop    = push && full && !do_pop;
    assign head    = mem[rd_ptr];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/ir_evt_ctrl.sv
module ir_evt_ctrl
    import ir_rx_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     count,
    input  logic [LVL_W-1:0]  level,
    input  logic              tmo_in,
    input  logic              ovf_in,
    input  logic [NUM_EV-1:0] clr,
    input  logic [NUM_EV-1:0] mask,
    output logic [NUM_EV-1:0] raw,
    output logic [NUM_EV-1:0] gated,
    output logic              irq
);
    logic [CW-1:0]     thresh;
    logic [NUM_EV-1:0] set;

    assign thresh      = CW'(level) + CW'(1);
    assign set[EV_RCV] = (count >= thresh);
    assign set[EV_TMO] = tmo_in;
    assign set[EV_OVF] = ovf_in;

    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~clr) | set;
    end

    assign gated = raw & ~mask;
    assign irq   = |gated;
endmodule

// File: rtl/ir_rx_regs.sv
module ir_rx_regs
    import ir_rx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        sym_valid,
    input  logic [31:0] sym_data,
    input  logic        timeout_evt,
    input  logic        cap_busy,
    output logic        cap_enable,
    output logic        cap_run,
    output logic [31:0] cap_config,
    output logic        irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic              wr_en, rd_en, pop_req;
    logic [31:0]       cfg_q;
    logic [NUM_EV-1:0] mask_q, clr_bits, evt_raw, evt_gated;
    logic [31:0]       fifo_head;
    logic [CW-1:0]     fifo_cnt;
    logic              fifo_empty, fifo_drop;

    assign wr_en   = bus_sel && bus_wr;
    assign rd_en   = bus_sel && !bus_wr;
    assign pop_req = rd_en && (bus_addr == A_DATA);
    assign clr_bits = (wr_en && bus_addr == A_CLEAR) ? bus_wdata[18:16] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (bus_addr == A_CONFIG) cfg_q  <= bus_wdata;
            if (bus_addr == A_MASK)   mask_q <= bus_wdata[NUM_EV-1:0];
        end
    end
    assign cap_config = cfg_q;

    ir_rx_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_wr      (wr_en && bus_addr == A_ENABLE),
        .en_bit     (bus_wdata[0]),
        .start_wr   (wr_en && bus_addr == A_START),
        .cap_enable (cap_enable),
        .cap_run    (cap_run)
    );

    ir_sym_fifo #(.DW(32), .DEPTH(DEPTH), .CW(CW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (sym_valid && cap_run),
        .push_data (sym_data),
        .pop       (pop_req),
        .head      (fifo_head),
        .count     (fifo_cnt),
        .empty     (fifo_empty),
        .drop      (fifo_drop)
    );

    ir_evt_ctrl #(.CW(CW)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .count  (fifo_cnt),
        .level  (cfg_q[LVL_LSB +: LVL_W]),
        .tmo_in (timeout_evt && cap_run),
        .ovf_in (fifo_drop),
        .clr    (clr_bits),
        .mask   (mask_q),
        .raw    (evt_raw),
        .gated  (evt_gated),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                A_ENABLE: bus_rdata = {31'b0, cap_enable};
                A_CONFIG: bus_rdata = cfg_q;
                A_BUSY:   bus_rdata = {31'b0, cap_busy};
                A_COUNT:  bus_rdata = 32'(fifo_cnt);
                A_DATA:   bus_rdata = fifo_empty ? '0 : fifo_head;
                A_MASK:   bus_rdata = {29'b0, mask_q};
                A_STATUS: bus_rdata = {5'b0, evt_raw, 13'b0, evt_gated, 8'b0};
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ir_rx_regs_chk.sv
module ir_rx_regs_chk
    import ir_rx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [7:0]    bus_addr,
    input logic [31:0]   bus_wdata,
    input logic          sym_valid,
    input logic          timeout_evt,
    input logic          cap_run,
    input logic          irq,
    input logic [CW-1:0] cnt,
    input logic [2:0]    raw,
    input logic [2:0]    mask
);
    logic pop_rq, push_rq, tmo_clr;
    assign pop_rq  = bus_sel && !bus_wr && bus_addr == A_DATA;
    assign push_rq = sym_valid && cap_run;
    assign tmo_clr = bus_sel && bus_wr && bus_addr == A_CLEAR && bus_wdata[17];

    a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push_rq && cnt == CW'(DEPTH) && !pop_rq) |=> (cnt == CW'(DEPTH) && raw[2]));

    a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_rq && cnt == '0 && !push_rq) |=> cnt == '0);

    a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_run && !pop_rq) |=> $stable(cnt));

    a_r7_tmo: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_evt && cap_run) |=> raw[1]);

    a_r9_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 3'b111) |-> !irq);

    a_r10_clr_tmo: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_clr && !(timeout_evt && cap_run)) |=> !raw[1]);
endmodule

bind ir_rx_regs ir_rx_regs_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .sym_valid   (sym_valid),
    .timeout_evt (timeout_evt),
    .cap_run     (cap_run),
    .irq         (irq),
    .cnt         (fifo_cnt),
    .raw         (evt_raw),
    .mask        (mask_q)
);

// File: tb/ir_rx_regs_test.sv
module ir_rx_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sym_valid = 1'b0;
    logic [31:0] sym_data = '0;
    logic        timeout_evt = 1'b0, cap_busy = 1'b0;
    logic        cap_enable, cap_run, irq;
    logic [31:0] cap_config;

    int total = 0, bad = 0;
    bit finished = 0;

    localparam logic [31:0] SYMS [6] = '{32'h0012_0034, 32'h3E80_0001, 32'hFFFF_FFFF,
                                         32'h0000_0000, 32'hA5A5_5A5A, 32'h0001_0002};
    localparam logic [31:0] CFG_L7  = 32'h3E80_0780 | 32'h18;
    localparam logic [31:0] CFG_L63 = 32'h3E80_3F80 | 32'h18;

    always #4 clk = ~clk;   // 125 MHz

    ir_rx_regs uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic push(input logic [31:0] v);
        @(negedge clk);
        sym_valid = 1; sym_data = v;
        @(posedge clk); #1;
        sym_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        rst_n = 1;
        // R1 reset state
        #1 chk("R1 irq", 32'(irq), 0);
        chk("R1 cap_run", 32'(cap_run), 0);
        rd(8'h20, r); chk("R1 count", r, 0);
        rd(8'h2C, r); chk("R1 status", r, 0);
        rd(8'h00, r); chk("R1 enable", r, 0);

        // R2 state gating
        wr(8'h34, 1); #1 chk("R2 start in OFF ignored", 32'(cap_run), 0);
        push(32'h1111); rd(8'h20, r); chk("R2 OFF push ignored", r, 0);
        wr(8'h00, 1); #1 chk("R2 arm enable", 32'(cap_enable), 1);
        chk("R2 arm not run", 32'(cap_run), 0);
        push(32'h2222); rd(8'h20, r); chk("R2 IDLE push ignored", r, 0);
        wr(8'h34, 32'h55); #1 chk("R2 go", 32'(cap_run), 1);

        // R11 config / mask
        wr(8'h04, CFG_L7); wr(8'h28, 0);
        rd(8'h04, r); chk("R11 config readback", r, CFG_L7);
        chk("R11 cap_config", cap_config, CFG_L7);

        // Table: R3 count, R4 order
        for (int i = 0; i < 6; i++) push(SYMS[i]);
        rd(8'h20, r); chk("R3 count", r, 6);
        rd(8'h2C, r); chk("R6 below threshold", r, 0);
        for (int i = 0; i < 6; i++) begin
            rd(8'h24, r); chk("R4 fifo order", r, SYMS[i]);
        end
        rd(8'h20, r); chk("R3 count drained", r, 0);

        // R5 empty read
        rd(8'h24, r); chk("R5 empty data", r, 0);
        rd(8'h20, r); chk("R5 empty count", r, 0);

        // R6 threshold (level 7 -> 8)
        for (int i = 0; i < 7; i++) push(32'(i + 100));
        rd(8'h2C, r); chk("R6 at level no event", r, 0);
        push(32'd107);
        rd(8'h2C, r); chk("R6 R9 rcv raw+masked", r, 32'h0100_0100);
        #1 chk("R9 irq rcv", 32'(irq), 1);
        wr(8'h30, 32'h0001_0000);
        rd(8'h2C, r); chk("R6 clear while above", r, 32'h0100_0100);
        rd(8'h24, r); chk("R4 oldest", r, 100);
        wr(8'h30, 32'h0001_0000);
        rd(8'h2C, r); chk("R10 rcv cleared", r, 0);
        #1 chk("R10 irq low", 32'(irq), 0);
        for (int i = 0; i < 7; i++) rd(8'h24, r);
        rd(8'h20, r); chk("R3 drained", r, 0);

        // R7 timeout, R9 masking, R10 selective clear
        @(negedge clk); timeout_evt = 1; @(posedge clk); #1 timeout_evt = 0;
        rd(8'h2C, r); chk("R7 timeout", r, 32'h0200_0200);
        wr(8'h28, 2);
        rd(8'h2C, r); chk("R9 masked timeout", r, 32'h0200_0000);
        #1 chk("R9 irq masked", 32'(irq), 0);
        rd(8'h28, r); chk("R11 mask readback", r, 2);
        wr(8'h30, 32'h0001_0000);
        rd(8'h2C, r); chk("R10 other bit no effect", r, 32'h0200_0000);
        wr(8'h30, 32'h0002_0000);
        rd(8'h2C, r); chk("R10 timeout cleared", r, 0);
        wr(8'h28, 0);

        // R8 overflow
        wr(8'h04, CFG_L63);
        for (int i = 0; i < 64; i++) push(32'(i + 32'h500));
        rd(8'h2C, r); chk("R8 full no overflow", r, 32'h0100_0100);
        push(32'hDEAD_BEEF);
        rd(8'h20, r); chk("R8 count held", r, 64);
        rd(8'h2C, r); chk("R8 overflow flag", r, 32'h0500_0500);
        rd(8'h24, r); chk("R8 oldest kept", r, 32'h500);
        for (int i = 1; i < 63; i++) rd(8'h24, r);
        rd(8'h24, r); chk("R8 newest kept, drop lost", r, 32'h53F);
        rd(8'h20, r); chk("R8 drained", r, 0);
        wr(8'h30, 32'h0005_0000);
        rd(8'h2C, r); chk("R10 overflow cleared", r, 0);

        // R11 busy
        cap_busy = 1;
        rd(8'h1C, r); chk("R11 busy", r, 1);
        cap_busy = 0;
        rd(8'h1C, r); chk("R11 not busy", r, 0);

        // R2 disarm
        wr(8'h00, 0);
        #1 chk("R2 disarm enable", 32'(cap_enable), 0);
        chk("R2 disarm run", 32'(cap_run), 0);
        push(32'h7777); rd(8'h20, r); chk("R2 push after disarm", r, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule